// File: doc/BRIEF.md
# Multi-Range Background Copy Sequencer

This block copies up to four configured windows of a slow source memory into on-chip destination memory while the processor keeps executing. Each slot holds an inclusive lower bound, an exclusive upper bound, a destination base and an enable. Enabled slots are handled one at a time, lowest slot first. Each word is read from the source port and then written to the destination port at the same offset from the destination base. Copy traffic is only offered in cycles where the processor bus reports itself idle.

Each slot exports a live progress pointer. Every source address below that pointer already holds a valid copy at the destination, so redirection logic can serve those addresses from fast memory before the whole window is finished. A failed read or write sets a sticky error interrupt, and all copying stops until software clears it. Slots whose bounds are malformed are flagged and skipped.

Top module: `bgcopy_seq`

## Requirements
- R1: A slot covers source byte addresses `a` with `lo <= a < hi`. Each word of DATA_W bits is read once at `a` and written with the same data to `dst + (a - lo)`, in rising address order. Addresses advance by DATA_W/8 bytes.
- R2: Enabled, well-formed slots are serviced one at a time in ascending slot index. No read for slot k is issued while a lower-indexed enabled slot is still incomplete, unless that slot was enabled after slot k began.
- R3: `rd_req_valid_o` and `wr_req_valid_o` are asserted only in cycles where `cpu_idle_i` is 1. A transfer happens on valid and ready in the same cycle. Holding `cpu_idle_i` at 0 stops all traffic.
- R4: Only one transaction is in flight at a time. A read is issued and its response taken, then the write is issued and its response taken, before the next read. No request is offered while a response is outstanding.
- R5: The progress pointer of slot n equals `lo + (DATA_W/8) × (successful write acknowledgements)`. It moves only when a write is acknowledged without error. It reads as `lo` while the slot is disabled, and it never leaves `[lo, hi)` while the slot is being copied.
- R6: `done_o[n]` rises in the cycle after the write of the slot's last word is acknowledged, at which point the progress pointer equals `hi`. It stays set while the slot is enabled and clears when the enable is removed.
- R7: A slot is malformed if bits `[PAGE_BITS-1:0]` of `lo` or `hi` are nonzero, or if `hi <= lo`. A malformed enabled slot has `bad_o[n]=1`, causes no memory access, and is skipped. The default PAGE_BITS of 12 gives 4 KB granules.
- R8: Clearing a slot's enable while it is being copied stops new requests for it. A transaction already accepted still completes, and then the next enabled slot starts. The slot's done bit stays 0.
- R9: A response with its error bit set, on either port, sets `err_irq_o`. After a read error no write is issued. After a write error the progress pointer does not advance. No request is offered until `err_clr_i` is pulsed. Copying then resumes from the progress pointer.
- R10: After reset no request is offered, `err_irq_o` is 0 and every done bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_lo_i | input | N_SLOTS*ADDR_W | Per-slot inclusive source lower bound, slot n at bits n*ADDR_W |
| cfg_hi_i | input | N_SLOTS*ADDR_W | Per-slot exclusive source upper bound |
| cfg_dst_i | input | N_SLOTS*ADDR_W | Per-slot destination base address |
| cfg_en_i | input | N_SLOTS | Per-slot copy enable |
| cpu_idle_i | input | 1 | Processor bus idle; copy requests are offered only when high |
| rd_req_valid_o | output | 1 | Source read request valid |
| rd_req_ready_i | input | 1 | Source port accepts the read request |
| rd_addr_o | output | ADDR_W | Source read byte address |
| rd_rsp_valid_i | input | 1 | Source read response valid |
| rd_rsp_data_i | input | DATA_W | Source read data |
| rd_rsp_err_i | input | 1 | Source read failed |
| wr_req_valid_o | output | 1 | Destination write request valid |
| wr_req_ready_i | input | 1 | Destination port accepts the write request |
| wr_addr_o | output | ADDR_W | Destination write byte address |
| wr_data_o | output | DATA_W | Destination write data |
| wr_rsp_valid_i | input | 1 | Destination write acknowledgement valid |
| wr_rsp_err_i | input | 1 | Destination write failed |
| err_clr_i | input | 1 | Software clear of the error interrupt |
| err_irq_o | output | 1 | Sticky copy error interrupt |
| done_o | output | N_SLOTS | Per-slot copy complete |
| bad_o | output | N_SLOTS | Per-slot malformed configuration flag |
| progress_o | output | N_SLOTS*ADDR_W | Per-slot progress pointer: source addresses below it are copied |

## Verification
The progress pointers and the slot index held by the sequencer are visible at the ports within a cycle. A wrong pointer shows up as a destination write to the wrong offset, or as a done bit rising with the pointer off the upper bound. A wrong slot index shows up as data from the wrong window or as slots finishing out of order. Both appear on the first word the fault touches. A stuck error or state register shows up either as a request offered while the interrupt is high, or as a copy that never completes, which the bench detects through its completion timeouts. The sweep over all sixteen enable masks compares every destination word and every pointer against values computed from the bounds.

// File: rtl/bgcopy_pkg.sv
package bgcopy_pkg;

    // Copy sequencer phases: one read/write pair in flight at most.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD_REQ  = 3'd1,
        ST_RD_WAIT = 3'd2,
        ST_WR_REQ  = 3'd3,
        ST_WR_WAIT = 3'd4
    } cp_state_e;

endpackage

// File: rtl/bgcopy_range_chk.sv
// Decides whether one slot's bounds describe a usable window.
module bgcopy_range_chk #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12
) (
    input  logic [ADDR_W-1:0] lo_i,
    input  logic [ADDR_W-1:0] hi_i,
    output logic              ok_o
);
    logic lo_aligned;
    logic hi_aligned;

    always_comb begin
        lo_aligned = (lo_i[PAGE_BITS-1:0] == '0);
        hi_aligned = (hi_i[PAGE_BITS-1:0] == '0);
        ok_o       = lo_aligned && hi_aligned && (hi_i > lo_i);
    end
endmodule

// File: rtl/bgcopy_pick.sv
// Fixed-priority choice of the lowest eligible slot.
module bgcopy_pick #(
    parameter int N_SLOTS = 4,
    parameter int IDX_W   = 2
) (
    input  logic [N_SLOTS-1:0] elig_i,
    output logic               valid_o,
    output logic [IDX_W-1:0]   idx_o
);
    always_comb begin
        valid_o = |elig_i;
        idx_o   = '0;
        for (int i = N_SLOTS - 1; i >= 0; i--) begin
            if (elig_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/bgcopy_seq.sv
module bgcopy_seq
    import bgcopy_pkg::*;
#(
    parameter int N_SLOTS   = 4,
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int PAGE_BITS = 12
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic [N_SLOTS*ADDR_W-1:0]   cfg_lo_i,
    input  logic [N_SLOTS*ADDR_W-1:0]   cfg_hi_i,
    input  logic [N_SLOTS*ADDR_W-1:0]   cfg_dst_i,
    input  logic [N_SLOTS-1:0]          cfg_en_i,
    input  logic                        cpu_idle_i,
    output logic                        rd_req_valid_o,
    input  logic                        rd_req_ready_i,
    output logic [ADDR_W-1:0]           rd_addr_o,
    input  logic                        rd_rsp_valid_i,
    input  logic [DATA_W-1:0]           rd_rsp_data_i,
    input  logic                        rd_rsp_err_i,
    output logic                        wr_req_valid_o,
    input  logic                        wr_req_ready_i,
    output logic [ADDR_W-1:0]           wr_addr_o,
    output logic [DATA_W-1:0]           wr_data_o,
    input  logic                        wr_rsp_valid_i,
    input  logic                        wr_rsp_err_i,
    input  logic                        err_clr_i,
    output logic                        err_irq_o,
    output logic [N_SLOTS-1:0]          done_o,
    output logic [N_SLOTS-1:0]          bad_o,
    output logic [N_SLOTS*ADDR_W-1:0]   progress_o
);
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int IDX_W      = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    typedef struct packed {
        cp_state_e                 st;
        logic [IDX_W-1:0]          cur;
        logic [DATA_W-1:0]         word;
        logic                      err;
        logic [N_SLOTS-1:0]        done;
        logic [N_SLOTS-1:0]        armed;   // enable seen in previous cycle
        logic [N_SLOTS*ADDR_W-1:0] prog;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [ADDR_W-1:0]  lo_a   [N_SLOTS];
    logic [ADDR_W-1:0]  hi_a   [N_SLOTS];
    logic [ADDR_W-1:0]  dst_a  [N_SLOTS];
    logic [ADDR_W-1:0]  prog_a [N_SLOTS];
    logic [N_SLOTS-1:0] slot_ok;
    logic [N_SLOTS-1:0] elig;
    logic               pick_v;
    logic [IDX_W-1:0]   pick_idx;

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        assign lo_a[g]   = cfg_lo_i[g*ADDR_W +: ADDR_W];
        assign hi_a[g]   = cfg_hi_i[g*ADDR_W +: ADDR_W];
        assign dst_a[g]  = cfg_dst_i[g*ADDR_W +: ADDR_W];
        assign prog_a[g] = seq_q.prog[g*ADDR_W +: ADDR_W];

        bgcopy_range_chk #(
            .ADDR_W    (ADDR_W),
            .PAGE_BITS (PAGE_BITS)
        ) u_chk (
            .lo_i (lo_a[g]),
            .hi_i (hi_a[g]),
            .ok_o (slot_ok[g])
        );
    end

    assign elig = cfg_en_i & seq_q.armed & slot_ok & ~seq_q.done;

    bgcopy_pick #(
        .N_SLOTS (N_SLOTS),
        .IDX_W   (IDX_W)
    ) u_pick (
        .elig_i  (elig),
        .valid_o (pick_v),
        .idx_o   (pick_idx)
    );

    logic              cur_en;
    logic [ADDR_W-1:0] cur_lo;
    logic [ADDR_W-1:0] cur_hi;
    logic [ADDR_W-1:0] cur_dst;
    logic [ADDR_W-1:0] cur_prog;
    logic [ADDR_W-1:0] cur_next;
    logic              advance;

    always_comb begin
        cur_en   = cfg_en_i[seq_q.cur];
        cur_lo   = lo_a[seq_q.cur];
        cur_hi   = hi_a[seq_q.cur];
        cur_dst  = dst_a[seq_q.cur];
        cur_prog = prog_a[seq_q.cur];
        cur_next = cur_prog + STEP;
        advance  = (seq_q.st == ST_WR_WAIT) && wr_rsp_valid_i && !wr_rsp_err_i;
    end

    always_comb begin
        seq_d = seq_q;
        if (err_clr_i) begin
            seq_d.err = 1'b0;
        end
        unique case (seq_q.st)
            ST_IDLE: begin
                if (pick_v && !seq_q.err) begin
                    seq_d.cur = pick_idx;
                    seq_d.st  = ST_RD_REQ;
                end
            end
            ST_RD_REQ: begin
                if (!cur_en) begin
                    seq_d.st = ST_IDLE;
                end else if (cpu_idle_i && rd_req_ready_i) begin
                    seq_d.st = ST_RD_WAIT;
                end
            end
            ST_RD_WAIT: begin
                if (rd_rsp_valid_i) begin
                    if (rd_rsp_err_i) begin
                        seq_d.err = 1'b1;
                        seq_d.st  = ST_IDLE;
                    end else if (!cur_en) begin
                        seq_d.st = ST_IDLE;
                    end else begin
                        seq_d.word = rd_rsp_data_i;
                        seq_d.st   = ST_WR_REQ;
                    end
                end
            end
            ST_WR_REQ: begin
                if (!cur_en) begin
                    seq_d.st = ST_IDLE;
                end else if (cpu_idle_i && wr_req_ready_i) begin
                    seq_d.st = ST_WR_WAIT;
                end
            end
            ST_WR_WAIT: begin
                if (wr_rsp_valid_i) begin
                    if (wr_rsp_err_i) begin
                        seq_d.err = 1'b1;
                        seq_d.st  = ST_IDLE;
                    end else if (cur_next == cur_hi) begin
                        seq_d.st = ST_IDLE;
                    end else begin
                        seq_d.st = ST_RD_REQ;
                    end
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase

        for (int n = 0; n < N_SLOTS; n++) begin
            if (advance && (int'(seq_q.cur) == n)) begin
                seq_d.prog[n*ADDR_W +: ADDR_W] = cur_next;
                if (cur_next == hi_a[n]) begin
                    seq_d.done[n] = 1'b1;
                end
            end
            seq_d.armed[n] = cfg_en_i[n];
            // A disabled or newly enabled slot restarts from its lower bound.
            if (!cfg_en_i[n] || !seq_q.armed[n]) begin
                seq_d.prog[n*ADDR_W +: ADDR_W] = lo_a[n];
                seq_d.done[n] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '{st: ST_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign rd_req_valid_o = (seq_q.st == ST_RD_REQ) && cur_en && cpu_idle_i;
    assign rd_addr_o      = cur_prog;
    assign wr_req_valid_o = (seq_q.st == ST_WR_REQ) && cur_en && cpu_idle_i;
    assign wr_addr_o      = cur_dst + (cur_prog - cur_lo);
    assign wr_data_o      = seq_q.word;
    assign err_irq_o      = seq_q.err;
    assign done_o         = seq_q.done;
    assign bad_o          = cfg_en_i & ~slot_ok;
    assign progress_o     = seq_q.prog;

    // R3: copy traffic only in processor-idle cycles
    p_idle_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_req_valid_o || wr_req_valid_o) |-> cpu_idle_i);

    // R4: an accepted write is followed by no read request
    p_single_txn_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_req_valid_o && wr_req_ready_i) |=> !rd_req_valid_o);

    // R5: pointer of the active slot stays inside its window
    p_prog_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.st != ST_IDLE) |-> (cur_prog >= cur_lo && cur_prog < cur_hi));

    // R7: a malformed slot never reaches the source port
    p_skip_bad_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_req_valid_o |-> !bad_o[seq_q.cur]);

    // R9: a pending error blocks every request
    p_err_halts_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_irq_o |-> (!rd_req_valid_o && !wr_req_valid_o));

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_done_chk
        // R6: completion coincides with the pointer reaching the upper bound
        p_done_at_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(done_o[g]) |-> (prog_a[g] == hi_a[g]));
    end
endmodule

// File: tb/sim_bgcopy_seq.sv
module sim_bgcopy_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NS  = 4;
    localparam int AW  = 16;
    localparam int DW  = 32;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [NS*AW-1:0] cfg_lo, cfg_hi, cfg_dst, progress;
    logic [NS-1:0]    en = '0, done, bad;
    logic             cpu_idle = 1'b0, rd_req_ready = 1'b0, wr_req_ready = 1'b0;
    logic             rd_req_valid, wr_req_valid, err_irq;
    logic [AW-1:0]    rd_addr, wr_addr;
    logic [DW-1:0]    wr_data, rd_rsp_data = '0;
    logic             rd_rsp_valid = 1'b0, rd_rsp_err = 1'b0;
    logic             wr_rsp_valid = 1'b0, wr_rsp_err = 1'b0;
    logic             err_clr = 1'b0;

    logic [AW-1:0] lo_b [NS];
    logic [AW-1:0] hi_b [NS];
    logic [AW-1:0] dst_b [NS];
    for (genvar g = 0; g < NS; g++) begin : g_cfg
        assign cfg_lo[g*AW +: AW]  = lo_b[g];
        assign cfg_hi[g*AW +: AW]  = hi_b[g];
        assign cfg_dst[g*AW +: AW] = dst_b[g];
    end

    bgcopy_seq #(.N_SLOTS(NS), .ADDR_W(AW), .DATA_W(DW), .PAGE_BITS(4)) u0 (
        .clk_i(clk), .rst_ni(rst_n),
        .cfg_lo_i(cfg_lo), .cfg_hi_i(cfg_hi), .cfg_dst_i(cfg_dst), .cfg_en_i(en),
        .cpu_idle_i(cpu_idle),
        .rd_req_valid_o(rd_req_valid), .rd_req_ready_i(rd_req_ready), .rd_addr_o(rd_addr),
        .rd_rsp_valid_i(rd_rsp_valid), .rd_rsp_data_i(rd_rsp_data), .rd_rsp_err_i(rd_rsp_err),
        .wr_req_valid_o(wr_req_valid), .wr_req_ready_i(wr_req_ready), .wr_addr_o(wr_addr),
        .wr_data_o(wr_data), .wr_rsp_valid_i(wr_rsp_valid), .wr_rsp_err_i(wr_rsp_err),
        .err_clr_i(err_clr), .err_irq_o(err_irq),
        .done_o(done), .bad_o(bad), .progress_o(progress)
    );

    int n_checks = 0;
    int n_errors = 0;

    // Bench memory model state
    logic [DW-1:0] dmem [256];
    int  rcnt [NS];
    int  wcnt [NS];
    int  cyc = 0;
    int  last_slot = 0;
    int  order_err = 0, map_err = 0, idle_err = 0, outst_err = 0;
    bit  force_busy = 0;
    bit  rd_pend = 0, wr_pend = 0, wr_pend_err = 0;
    logic [AW-1:0] rd_pend_addr = '0;
    bit  inj_rd_arm = 0, inj_wr_arm = 0;
    logic [AW-1:0] inj_rd_addr = '0, inj_wr_addr = '0;

    function automatic logic [DW-1:0] src_word(logic [AW-1:0] a);
        return {a ^ 16'h5A5A, a} | 32'h8000_0000;
    endfunction

    function automatic int src_slot(logic [AW-1:0] a);
        return a[13] ? 3 : int'(a[9:8]);
    endfunction

    function automatic int dst_slot(logic [AW-1:0] a);
        if (a < 16'h0080) return 0;
        if (a < 16'h0100) return 1;
        if (a < 16'h0200) return 2;
        return 3;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Memory model: responses and ready/idle change at the falling edge,
    // handshakes for the coming rising edge are predicted just after.
    initial begin
        forever begin
            @(negedge clk);
            rd_rsp_valid = 1'b0; rd_rsp_err = 1'b0;
            wr_rsp_valid = 1'b0; wr_rsp_err = 1'b0;
            if (rd_pend) begin
                rd_rsp_valid = 1'b1;
                rd_rsp_data  = src_word(rd_pend_addr);
                if (inj_rd_arm && rd_pend_addr == inj_rd_addr) begin
                    rd_rsp_err = 1'b1;
                    inj_rd_arm = 0;
                end
                rd_pend = 0;
            end
            if (wr_pend) begin
                wr_rsp_valid = 1'b1;
                wr_rsp_err   = wr_pend_err;
                wr_pend = 0;
                wr_pend_err = 0;
            end
            cyc++;
            cpu_idle     = !force_busy && (cyc % 5 != 0);
            rd_req_ready = (cyc % 3 != 1);
            wr_req_ready = (cyc % 4 != 2);
            #1;
            if ((rd_req_valid || wr_req_valid) && !cpu_idle) idle_err++;
            if (((rd_req_valid && rd_req_ready) || (wr_req_valid && wr_req_ready)) &&
                (rd_rsp_valid || wr_rsp_valid)) outst_err++;
            if (rd_req_valid && rd_req_ready) begin
                int s;
                s = src_slot(rd_addr);
                if (s < last_slot) order_err++;
                last_slot = s;
                rcnt[s]++;
                rd_pend = 1;
                rd_pend_addr = rd_addr;
            end
            if (wr_req_valid && wr_req_ready) begin
                int s;
                logic [AW-1:0] sa;
                s  = dst_slot(wr_addr);
                sa = lo_b[s] + (wr_addr - dst_b[s]);
                if (s < last_slot) order_err++;
                if (wr_data != src_word(sa)) map_err++;
                wcnt[s]++;
                wr_pend = 1;
                if (inj_wr_arm && wr_addr == inj_wr_addr) begin
                    wr_pend_err = 1;
                    inj_wr_arm = 0;
                end else begin
                    dmem[wr_addr[9:2]] = wr_data;
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic default_cfg();
        lo_b[0] = 16'h1000; hi_b[0] = 16'h1020; dst_b[0] = 16'h0000;
        lo_b[1] = 16'h1100; hi_b[1] = 16'h1110; dst_b[1] = 16'h0080;
        lo_b[2] = 16'h1200; hi_b[2] = 16'h1230; dst_b[2] = 16'h0100;
        lo_b[3] = 16'h2000; hi_b[3] = 16'h2010; dst_b[3] = 16'h0200;
    endtask

    task automatic clear_run();
        for (int i = 0; i < 256; i++) dmem[i] = '0;
        for (int s = 0; s < NS; s++) begin rcnt[s] = 0; wcnt[s] = 0; end
        last_slot = 0; order_err = 0; map_err = 0; idle_err = 0; outst_err = 0;
    endtask

    task automatic wait_done(input logic [NS-1:0] m, input string tag);
        int t;
        t = 0;
        while (((done & m) != m) && t < 3000) begin step(); t++; end
        chk((done & m) == m, tag, done, m);
    endtask

    function automatic int words_of(int s);
        return int'(hi_b[s] - lo_b[s]) / 4;
    endfunction

    task automatic check_mem(input int s, input bit copied, input string tag);
        int bad_words;
        bad_words = 0;
        for (int w = 0; w < words_of(s); w++) begin
            logic [AW-1:0] da;
            logic [DW-1:0] e;
            da = dst_b[s] + AW'(4 * w);
            e  = copied ? src_word(lo_b[s] + AW'(4 * w)) : '0;
            if (dmem[da[9:2]] !== e) bad_words++;
        end
        chk(bad_words == 0, tag, bad_words, 0);
    endtask

    task automatic run_mask(input logic [NS-1:0] m);
        en = '0;
        repeat (3) step();
        clear_run();
        en = m;
        wait_done(m, "R6 done set for enabled mask");
        repeat (2) step();
        chk(done == m, "R6 done equals mask", done, m);
        for (int s = 0; s < NS; s++) begin
            logic [AW-1:0] ep;
            ep = m[s] ? hi_b[s] : lo_b[s];
            chk(progress[s*AW +: AW] == ep, "R5 progress pointer", progress[s*AW +: AW], ep);
            check_mem(s, m[s], "R1 destination contents");
            chk(rcnt[s] == (m[s] ? words_of(s) : 0), "R1 read count", rcnt[s], m[s] ? words_of(s) : 0);
        end
        chk(order_err == 0, "R2 ascending slot order", order_err, 0);
        chk(map_err == 0, "R1 write data matches source", map_err, 0);
        chk(idle_err == 0, "R3 requests only while idle", idle_err, 0);
        chk(outst_err == 0, "R4 single outstanding", outst_err, 0);
        chk(err_irq == 1'b0, "R9 no error in clean run", err_irq, 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired actual=%0d expected=<%0d", WATCHDOG, WATCHDOG);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        default_cfg();
        clear_run();
        repeat (3) step();
        chk(!rd_req_valid && !wr_req_valid, "R10 no request in reset", {rd_req_valid, wr_req_valid}, 0);
        rst_n = 1'b1;
        repeat (3) step();
        chk(done == '0, "R10 done clear after reset", done, 0);
        chk(err_irq == 1'b0, "R10 error clear after reset", err_irq, 0);
        chk(rcnt[0] + rcnt[1] + rcnt[2] + rcnt[3] == 0, "R10 no traffic with no enable", rcnt[0], 0);

        // Sweep every enable combination
        for (int m = 0; m < 16; m++) run_mask(m[NS-1:0]);

        // R3: busy processor bus holds off all copying
        en = '0; repeat (3) step(); clear_run();
        force_busy = 1;
        en = 4'b0001;
        repeat (40) step();
        chk(rcnt[0] == 0 && wcnt[0] == 0, "R3 no traffic while busy", rcnt[0] + wcnt[0], 0);
        chk(progress[0 +: AW] == lo_b[0], "R3 pointer held while busy", progress[0 +: AW], lo_b[0]);
        force_busy = 0;
        wait_done(4'b0001, "R3 completes after idle returns");
        check_mem(0, 1, "R3 contents after idle returns");

        // R7: malformed slots are flagged and skipped
        en = '0; repeat (3) step(); clear_run();
        lo_b[2] = 16'h1204;
        lo_b[3] = 16'h2010;
        hi_b[3] = 16'h2010;
        en = 4'b1111;
        wait_done(4'b0011, "R7 good slots complete");
        repeat (4) step();
        chk(bad == 4'b1100, "R7 bad flags", bad, 4'b1100);
        chk(done == 4'b0011, "R7 bad slots not done", done, 4'b0011);
        chk(rcnt[2] + rcnt[3] + wcnt[2] + wcnt[3] == 0, "R7 no access to bad slots",
            rcnt[2] + rcnt[3] + wcnt[2] + wcnt[3], 0);
        chk(progress[2*AW +: AW] == 16'h1204, "R7 pointer stays at bound", progress[2*AW +: AW], 16'h1204);
        en = '0; repeat (2) step();
        default_cfg();

        // R8: disabling the active slot hands over to the next one
        clear_run();
        en = 4'b0011;
        begin
            int t;
            t = 0;
            while (wcnt[0] < 3 && t < 2000) begin step(); t++; end
        end
        en = 4'b0010;
        begin
            int w0;
            w0 = wcnt[0];
            wait_done(4'b0010, "R8 next slot completes");
            repeat (4) step();
            chk(wcnt[0] == w0, "R8 no new slot-0 writes after disable", wcnt[0], w0);
        end
        chk(done[0] == 1'b0, "R8 disabled slot not done", done[0], 0);
        chk(wcnt[1] == 4, "R8 next slot fully written", wcnt[1], 4);
        check_mem(1, 1, "R8 next slot contents");
        chk(progress[0 +: AW] == lo_b[0], "R8 disabled pointer at lower bound", progress[0 +: AW], lo_b[0]);

        // R9: read error freezes copying until cleared, then resumes
        en = '0; repeat (3) step(); clear_run();
        inj_rd_addr = 16'h1210; inj_rd_arm = 1;
        en = 4'b0100;
        begin
            int t;
            t = 0;
            while (!err_irq && t < 2000) begin step(); t++; end
        end
        chk(err_irq == 1'b1, "R9 read error raises interrupt", err_irq, 1);
        chk(progress[2*AW +: AW] == 16'h1210, "R9 pointer stops at failed word", progress[2*AW +: AW], 16'h1210);
        chk(wcnt[2] == 4, "R9 no write for failed read", wcnt[2], 4);
        begin
            int r0;
            r0 = rcnt[2];
            repeat (30) step();
            chk(rcnt[2] == r0 && wcnt[2] == 4, "R9 traffic frozen while error pending", rcnt[2], r0);
        end
        err_clr = 1'b1; step(); err_clr = 1'b0;
        wait_done(4'b0100, "R9 resumes after clear");
        check_mem(2, 1, "R9 contents after read error");
        chk(rcnt[2] == 13, "R9 reads resume at failed word", rcnt[2], 13);

        // R9: write error leaves the pointer in place
        en = '0; repeat (3) step(); clear_run();
        inj_wr_addr = 16'h0208; inj_wr_arm = 1;
        en = 4'b1000;
        begin
            int t;
            t = 0;
            while (!err_irq && t < 2000) begin step(); t++; end
        end
        chk(err_irq == 1'b1, "R9 write error raises interrupt", err_irq, 1);
        chk(progress[3*AW +: AW] == 16'h2008, "R9 pointer not advanced on write error",
            progress[3*AW +: AW], 16'h2008);
        chk(done[3] == 1'b0, "R9 slot incomplete after error", done[3], 0);
        err_clr = 1'b1; step(); err_clr = 1'b0;
        wait_done(4'b1000, "R9 resumes after write error");
        check_mem(3, 1, "R9 contents after write error");
        chk(wcnt[3] == 5, "R9 failed word rewritten once", wcnt[3], 5);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule